// File: doc/BRIEF.md
# Alternating Step Keystream Generator

This block produces one pseudo-random keystream bit per enabled clock cycle. It holds three binary linear feedback shift registers of different lengths. The control register advances on every enabled step. Its output cell decides which of the two data registers advances on that step: register A when the control bit is one, register B when it is zero. In alternating mode the keystream bit is the XOR of the two data registers' output cells after the step. This makes the clocking of the data registers irregular, which breaks the linearity of a single register.

A mode input selects a simpler stop-and-go variant. In that variant, register A advances on a step only if the control output seen on the previous step was one. Register B holds its state, and the keystream bit is register A's output cell. Software or an upstream controller loads three seed words with `load` and then raises `en` for as many steps as it needs. Each new bit appears with `ks_valid` one cycle after the step that made it.

Top module: `asg_keystream`

## Requirements
- R1: While `rst` is high, at the next clock edge `ks_valid` and `ks_bit` go to 0 and the three registers take their default seeds: control 19'h4F1A3, A 22'h2C5E71, B 23'h63D0B5. The remembered control bit is cleared. Reset wins over `load` and `en`.
- R2: A cycle with `load` high copies `seed_c`, `seed_a` and `seed_b` into the registers, clears the remembered control bit and drives `ks_valid` to 0 at the next edge. A seed word that is all zero is stored as the value 1, so no register is ever all zero.
- R3: Every register is a Fibonacci LFSR. Each of its cells moves up by one. Cell 0 receives the XOR of the tapped cells, taken before the shift. The register's output is its top cell, L-1. The default tapped cells are: control (L=19) cells 18, 17, 16 and 13; A (L=22) cells 21 and 20; B (L=23) cells 22 and 17. In alternating mode (`mode`=0), each enabled step advances the control register, and it advances A if the control top cell was 1 or B if it was 0.
- R4: In alternating mode the bit reported for a step is the XOR of the top cells of A and B after that step.
- R5: In stop-and-go mode (`mode`=1), A advances on a step only if the control top cell at the previous step was 1. B does not change. The bit reported is A's top cell after the step.
- R6: `ks_valid` is 1 in the cycle after each enabled step, and 0 after a cycle without a step.
- R7: A cycle with `en` low changes no register state. The sequence resumes afterwards exactly where it stopped.
- R8: `load` takes priority over `en`. A cycle with both high loads the seeds and performs no step.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | Load the three seed words |
| seed_c | input | 19 | Seed for the control register |
| seed_a | input | 22 | Seed for data register A |
| seed_b | input | 23 | Seed for data register B |
| en | input | 1 | Perform one step this cycle |
| mode | input | 1 | 0 = alternating, 1 = stop-and-go |
| ks_bit | output | 1 | Keystream bit of the last step |
| ks_valid | output | 1 | `ks_bit` belongs to a step made in the previous cycle |

## Verification
The assertions assume that `rst` is high at the first clock edge. Until then the register contents are undefined, and the nonzero-state properties only make sense after a reset has placed known seeds. They also assume that `mode` is a clean 0 or 1 on every step, because the hold properties for A and B are conditioned on it. The stimulus holds reset from time zero and drives every input at the falling edge, so all inputs are stable at the edge where they are sampled. It mixes all-zero, all-one and single-bit seeds, idle gaps and mid-stream mode and reset changes, without ever leaving `mode` undefined.

// File: rtl/asg_pkg.sv
package asg_pkg;

  typedef enum logic {
    MODE_ALT    = 1'b0,
    MODE_STOPGO = 1'b1
  } ks_mode_e;

  localparam int DEF_LEN_C = 19;
  localparam int DEF_LEN_A = 22;
  localparam int DEF_LEN_B = 23;

endpackage

// File: rtl/asg_lfsr.sv
module asg_lfsr #(
  parameter int          LEN  = 19,
  parameter logic [LEN-1:0] TAPS = '1,
  parameter logic [LEN-1:0] INIT = 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic [LEN-1:0] seed,
  input  logic           adv,
  output logic [LEN-1:0] state,
  output logic           top_now,
  output logic           top_next
);

  localparam logic [LEN-1:0] ONE = {{(LEN-1){1'b0}}, 1'b1};

  logic [LEN-1:0] seed_ok;
  logic [LEN-1:0] tapped;
  logic           fb;

  // mask out untapped cells, then fold with XOR
  genvar gi;
  generate
    for (gi = 0; gi < LEN; gi++) begin : g_tap
      if (TAPS[gi]) begin : g_on
        assign tapped[gi] = state[gi];
      end else begin : g_off
        assign tapped[gi] = 1'b0;
      end
    end
  endgenerate

  assign fb      = ^tapped;
  assign seed_ok = (seed == '0) ? ONE : seed;

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= INIT;
    end else if (load) begin
      state <= seed_ok;
    end else if (adv) begin
      state <= {state[LEN-2:0], fb};
    end
  end

  assign top_now  = state[LEN-1];
  assign top_next = adv ? state[LEN-2] : state[LEN-1];

endmodule

// File: rtl/asg_gate.sv
module asg_gate
  import asg_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     load,
  input  logic     en,
  input  ks_mode_e mode,
  input  logic     c_top,
  output logic     step,
  output logic     adv_c,
  output logic     adv_a,
  output logic     adv_b,
  output logic     prev_c
);

  assign step  = en & ~load;
  assign adv_c = step;

  always_comb begin
    adv_a = 1'b0;
    adv_b = 1'b0;
    unique case (mode)
      MODE_ALT: begin
        adv_a = step & c_top;
        adv_b = step & ~c_top;
      end
      MODE_STOPGO: begin
        adv_a = step & prev_c;
        adv_b = 1'b0;
      end
      default: begin
        adv_a = 1'b0;
        adv_b = 1'b0;
      end
    endcase
  end

  // control output of the previous step
  always_ff @(posedge clk) begin
    if (rst || load) begin
      prev_c <= 1'b0;
    end else if (step) begin
      prev_c <= c_top;
    end
  end

endmodule

// File: rtl/asg_keystream.sv
module asg_keystream
  import asg_pkg::*;
#(
  parameter int LEN_C = DEF_LEN_C,
  parameter int LEN_A = DEF_LEN_A,
  parameter int LEN_B = DEF_LEN_B,
  parameter logic [LEN_C-1:0] TAPS_C = 19'h72000,
  parameter logic [LEN_A-1:0] TAPS_A = 22'h300000,
  parameter logic [LEN_B-1:0] TAPS_B = 23'h420000,
  parameter logic [LEN_C-1:0] INIT_C = 19'h4F1A3,
  parameter logic [LEN_A-1:0] INIT_A = 22'h2C5E71,
  parameter logic [LEN_B-1:0] INIT_B = 23'h63D0B5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [LEN_C-1:0] seed_c,
  input  logic [LEN_A-1:0] seed_a,
  input  logic [LEN_B-1:0] seed_b,
  input  logic             en,
  input  logic             mode,
  output logic             ks_bit,
  output logic             ks_valid
);

  ks_mode_e         mode_e;
  logic             step, adv_c, adv_a, adv_b, prev_c;
  logic [LEN_C-1:0] c_state;
  logic [LEN_A-1:0] a_state;
  logic [LEN_B-1:0] b_state;
  logic             c_top, c_top_nx;
  logic             a_top, a_top_nx;
  logic             b_top, b_top_nx;
  logic             bit_nx;

  assign mode_e = ks_mode_e'(mode);

  asg_gate u_gate (
    .clk    (clk),
    .rst    (rst),
    .load   (load),
    .en     (en),
    .mode   (mode_e),
    .c_top  (c_top),
    .step   (step),
    .adv_c  (adv_c),
    .adv_a  (adv_a),
    .adv_b  (adv_b),
    .prev_c (prev_c)
  );

  asg_lfsr #(.LEN(LEN_C), .TAPS(TAPS_C), .INIT(INIT_C)) u_ctl (
    .clk(clk), .rst(rst), .load(load), .seed(seed_c), .adv(adv_c),
    .state(c_state), .top_now(c_top), .top_next(c_top_nx)
  );

  asg_lfsr #(.LEN(LEN_A), .TAPS(TAPS_A), .INIT(INIT_A)) u_dat_a (
    .clk(clk), .rst(rst), .load(load), .seed(seed_a), .adv(adv_a),
    .state(a_state), .top_now(a_top), .top_next(a_top_nx)
  );

  asg_lfsr #(.LEN(LEN_B), .TAPS(TAPS_B), .INIT(INIT_B)) u_dat_b (
    .clk(clk), .rst(rst), .load(load), .seed(seed_b), .adv(adv_b),
    .state(b_state), .top_now(b_top), .top_next(b_top_nx)
  );

  assign bit_nx = (mode_e == MODE_STOPGO) ? a_top_nx : (a_top_nx ^ b_top_nx);

  always_ff @(posedge clk) begin
    if (rst) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else if (load) begin
      ks_bit   <= 1'b0;
      ks_valid <= 1'b0;
    end else if (step) begin
      ks_bit   <= bit_nx;
      ks_valid <= 1'b1;
    end else begin
      ks_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/asg_keystream_chk.sv
module asg_keystream_chk #(
  parameter int LC = 19,
  parameter int LA = 22,
  parameter int LB = 23
) (
  input logic          clk,
  input logic          rst,
  input logic          load,
  input logic          en,
  input logic          mode,
  input logic          ks_valid,
  input logic          prev_c,
  input logic [LC-1:0] c_q,
  input logic [LA-1:0] a_q,
  input logic [LB-1:0] b_q
);

  logic c_out;
  assign c_out = c_q[LC-1];

  AST_VALID_AFTER_STEP: assert property (@(posedge clk) disable iff (rst)
    (en && !load) |=> ks_valid);  // R6

  AST_NO_VALID_IDLE: assert property (@(posedge clk) disable iff (rst)
    (!en) |=> !ks_valid);  // R6

  AST_LOAD_CLEARS_VALID: assert property (@(posedge clk) disable iff (rst)
    load |=> !ks_valid);  // R2

  AST_IDLE_HOLDS_CTL: assert property (@(posedge clk) disable iff (rst)
    (!en && !load) |=> $stable(c_q));  // R7

  AST_ALT_B_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !mode && c_out) |=> $stable(b_q));  // R3

  AST_ALT_A_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (en && !load && !mode && !c_out) |=> $stable(a_q));  // R3

  AST_SG_A_GATED: assert property (@(posedge clk) disable iff (rst)
    (en && !load && mode && !prev_c) |=> $stable(a_q));  // R5

  AST_SG_B_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (en && !load && mode) |=> $stable(b_q));  // R5

  AST_NONZERO_STATE: assert property (@(posedge clk) disable iff (rst)
    (c_q != '0) && (a_q != '0) && (b_q != '0));  // R2

endmodule

bind asg_keystream asg_keystream_chk #(.LC(LEN_C), .LA(LEN_A), .LB(LEN_B)) u_chk (
  .clk      (clk),
  .rst      (rst),
  .load     (load),
  .en       (en),
  .mode     (mode),
  .ks_valid (ks_valid),
  .prev_c   (prev_c),
  .c_q      (c_state),
  .a_q      (a_state),
  .b_q      (b_state)
);

// File: tb/asg_keystream_bench.sv
module asg_keystream_bench;

  localparam int LC = 19;
  localparam int LA = 22;
  localparam int LB = 23;
  localparam logic [31:0] MC = 32'h72000;
  localparam logic [31:0] MA = 32'h300000;
  localparam logic [31:0] MB = 32'h420000;

  typedef struct packed {
    logic        md;
    logic [31:0] sc;
    logic [31:0] sa;
    logic [31:0] sb;
    logic [15:0] steps;
    logic [3:0]  gap;
  } vec_t;

  localparam vec_t VECS [6] = '{
    '{1'b0, 32'h12345, 32'h2ABCDE, 32'h7F0F0F, 16'd120, 4'd0},
    '{1'b0, 32'h0,     32'h0,      32'h0,      16'd80,  4'd5},
    '{1'b1, 32'h7FFFF, 32'h3FFFFF, 32'h7FFFFF, 16'd120, 4'd0},
    '{1'b1, 32'h1,     32'h1,      32'h1,      16'd80,  4'd7},
    '{1'b0, 32'h40000, 32'h200000, 32'h400000, 16'd100, 4'd3},
    '{1'b1, 32'h55555, 32'h155555, 32'h2AAAAA, 16'd100, 4'd0}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic load = 1'b0;
  logic en = 1'b0;
  logic mode = 1'b0;
  logic [LC-1:0] seed_c = '0;
  logic [LA-1:0] seed_a = '0;
  logic [LB-1:0] seed_b = '0;
  logic ks_bit, ks_valid;

  int total = 0;
  int bad = 0;

  logic [31:0] mc, ma, mb;
  logic        mprev;

  always #2 clk = ~clk;

  asg_keystream u_asg_keystream (
    .clk(clk), .rst(rst), .load(load),
    .seed_c(seed_c), .seed_a(seed_a), .seed_b(seed_b),
    .en(en), .mode(mode), .ks_bit(ks_bit), .ks_valid(ks_valid)
  );

  function automatic logic [31:0] shift_up(logic [31:0] s, int len, logic [31:0] m);
    logic fb;
    fb = ^(s & m);
    return ((s << 1) | {31'b0, fb}) & ((32'h1 << len) - 1);
  endfunction

  function automatic logic [31:0] fix0(logic [31:0] s, int len);
    logic [31:0] v;
    v = s & ((32'h1 << len) - 1);
    return (v == 0) ? 32'h1 : v;
  endfunction

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b", req, act, exp);
    end
  endtask

  task automatic model_defaults();
    mc = 32'h4F1A3; ma = 32'h2C5E71; mb = 32'h63D0B5; mprev = 1'b0;
  endtask

  // one enabled step; checks the bit and valid one cycle later
  task automatic do_step(logic m, string req);
    logic co, exp;
    co = mc[LC-1];
    if (!m) begin
      if (co) ma = shift_up(ma, LA, MA);
      else    mb = shift_up(mb, LB, MB);
      exp = ma[LA-1] ^ mb[LB-1];
    end else begin
      if (mprev) ma = shift_up(ma, LA, MA);
      exp = ma[LA-1];
    end
    mprev = co;
    mc = shift_up(mc, LC, MC);
    en = 1'b1; mode = m;
    @(posedge clk); @(negedge clk);
    chk("R6", ks_valid, 1'b1);
    chk(req, ks_bit, exp);
  endtask

  task automatic do_idle();
    en = 1'b0;
    @(posedge clk); @(negedge clk);
    chk("R6 R7 idle", ks_valid, 1'b0);
  endtask

  // load with en high: load must win (R8)
  task automatic do_load(logic [31:0] sc, logic [31:0] sa, logic [31:0] sb);
    load = 1'b1; en = 1'b1;
    seed_c = sc[LC-1:0]; seed_a = sa[LA-1:0]; seed_b = sb[LB-1:0];
    mc = fix0(sc, LC); ma = fix0(sa, LA); mb = fix0(sb, LB); mprev = 1'b0;
    @(posedge clk); @(negedge clk);
    load = 1'b0; en = 1'b0;
    chk("R2 R8 load", ks_valid, 1'b0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset valid", ks_valid, 1'b0);
    chk("R1 reset bit", ks_bit, 1'b0);
    rst = 1'b0;
    model_defaults();
    for (int i = 0; i < 40; i++) do_step(1'b0, "R1 R3 R4 default seeds");

    for (int v = 0; v < 6; v++) begin
      do_load(VECS[v].sc, VECS[v].sa, VECS[v].sb);
      for (int s = 0; s < int'(VECS[v].steps); s++) begin
        if (VECS[v].gap != 0 && (s % int'(VECS[v].gap)) == 0) do_idle();
        if (VECS[v].md) do_step(1'b1, "R5 stop-and-go R2 R7");
        else            do_step(1'b0, "R3 R4 alternating R2 R7");
      end
    end

    // mode change mid-stream: B must hold through stop-and-go (R5)
    do_load(32'h3C3C3, 32'h1F00F1, 32'h0ABCDE);
    for (int i = 0; i < 30; i++) do_step(1'b0, "R4 before switch");
    for (int i = 0; i < 40; i++) do_step(1'b1, "R5 after switch");
    for (int i = 0; i < 40; i++) do_step(1'b0, "R5 B held then R4");

    // reset during stepping, together with load: reset wins (R1)
    en = 1'b1; rst = 1'b1; load = 1'b1;
    seed_c = '1; seed_a = '1; seed_b = '1;
    @(posedge clk); @(negedge clk);
    chk("R1 reset mid-run valid", ks_valid, 1'b0);
    chk("R1 reset mid-run bit", ks_bit, 1'b0);
    rst = 1'b0; load = 1'b0; en = 1'b0;
    model_defaults();
    for (int i = 0; i < 30; i++) do_step(1'b1, "R1 R5 defaults after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule